// File: doc/BRIEF.md
# AC-link input frame serializer

This block is the codec-side transmitter for the serial line that carries status and record data from codec to controller. It runs on the serial bit clock. It watches the frame strobe on falling clock edges. When it sees a low-to-high change, it drives a new 256-bit frame on the serial output. The first bit goes out on the next rising edge, and each later bit goes out on a following rising edge, so the receiver can sample it on the falling edge after that.

The frame opens with a 16-bit tag slot. Twelve 20-bit slots follow. Slot 1 carries the register index echo and the variable-rate request bits. Slot 2 carries register read data. Slots 3 and 4 carry the left and right record samples. Slots 5 to 12 are always zero. Every bit position that holds no valid data is driven low.

All parallel inputs are loaded at the frame start, so changes during a frame do not disturb the bits already being shifted out. The register file, the converters, decoding of the outgoing direction and power management all live elsewhere.

Top module: `aclink_in_serializer`

## Requirements
- R1: A rising edge of `frame_sync` is detected on a falling edge of `ser_clk`. On the next rising edge, `ser_out` shows frame bit 0, which is slot 0 bit 15 and equals `dev_ready`.
- R2: A frame is slot 0 (16 bits) followed by slots 1 to 12 (20 bits each), 256 bits in total. Every slot is sent MSB first, one bit per rising edge.
- R3: Slot 0 carries the valid tags. Bit 14 (slot 1) and bit 13 (slot 2) both equal `reg_valid`. Bit 12 (slot 3) equals `rec_left_valid`. Bit 11 (slot 4) equals `rec_right_valid`. Bits 10:0 are 0.
- R4: Slot 1 layout: bit 19 is 0. Bits 18:12 carry `reg_idx` when `reg_valid` is 1 and are 0 otherwise. Bits 11:2 always carry `rate_req`, whatever the tag says. Bits 1:0 are 0.
- R5: Slot 2 holds `reg_data` in bits 19:4 with bits 3:0 at 0 when `reg_valid` is 1. When `reg_valid` is 0, all 20 bits of slot 2 are 0.
- R6: Slots 3 and 4 hold the ADC_W-bit left and right samples in bits 19:(20-ADC_W), MSB first, with the trailing bits at 0. A slot whose valid flag is 0 is all 0.
- R7: Slots 5 to 12 are all 0.
- R8: All parallel inputs are taken at the rising edge that sends bit 0. Later changes have no effect on the frame in progress.
- R9: `ser_out` is 0 during and after reset. It is also 0 after bit 255 until the next frame starts.
- R10: A new rising edge of `frame_sync` at any point, including mid-frame or on bit 255, restarts the frame at bit 0 on the following rising edge.
- R11: Holding `frame_sync` high, or letting it fall, never starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame strobe from the controller |
| dev_ready | input | 1 | Codec ready flag |
| reg_idx | input | 7 | Index of the register being returned |
| reg_data | input | 16 | Register read data |
| reg_valid | input | 1 | Register index and data are valid |
| rate_req | input | 10 | Variable-rate slot request bits |
| rec_left | input | ADC_W | Left record sample |
| rec_left_valid | input | 1 | Left sample valid |
| rec_right | input | ADC_W | Right record sample |
| rec_right_valid | input | 1 | Right sample valid |
| ser_out | output | 1 | Serial data-in line |

## Verification
The hardest case to reach from the ports is a frame start that does not follow an idle gap. This covers a strobe edge on the last bit of a frame and a strobe edge partway through a frame. In both, the loaded shift contents must be thrown away at exactly the right edge. The stimulus reaches these cases by raising the strobe inside the bit loop of the previous frame, on bit 255 for the back-to-back case and on bit 100 for the restart case. It then checks every bit of the new frame. Capture at frame start is exercised by scrambling all parallel inputs right after bit 1 of every frame.

// File: rtl/aclink_in_pkg.sv
package aclink_in_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + NUM_SLOTS * SLOT_W;
    localparam int IDX_W     = 7;
    localparam int RDATA_W   = 16;
    localparam int REQ_W     = 10;
    localparam int REQ_LSB   = 2;
    localparam int USED_SLOTS = 4;

    typedef logic [SLOT_W-1:0]  slot_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic               ready;
        logic [IDX_W-1:0]   idx;
        logic [RDATA_W-1:0] data;
        logic               valid;
        logic [REQ_W-1:0]   req;
    } status_t;

    // tag slot: ready flag on top, one valid flag per data slot below it
    function automatic tag_t make_tag(logic ready, logic [NUM_SLOTS-1:0] valid);
        tag_t t;
        t = '0;
        t[TAG_W-1] = ready;
        t[TAG_W-2 -: NUM_SLOTS] = valid;
        return t;
    endfunction

    // slot 1: index echo gated by tag, request bits always present
    function automatic slot_t make_addr_slot(status_t s);
        slot_t r;
        r = '0;
        if (s.valid) r[SLOT_W-2 -: IDX_W] = s.idx;
        r[REQ_LSB+REQ_W-1 -: REQ_W] = s.req;
        return r;
    endfunction

    // slot 2: read data left-justified, blank when untagged
    function automatic slot_t make_data_slot(status_t s);
        slot_t r;
        r = '0;
        if (s.valid) r[SLOT_W-1 -: RDATA_W] = s.data;
        return r;
    endfunction
endpackage

// File: rtl/aclink_sync_detect.sv
module aclink_sync_detect (
    input  logic ser_clk,
    input  logic rst,
    input  logic frame_sync,
    output logic start
);
    logic sync_q;

    // strobe is sampled on the falling edge, half a bit after it changes
    always_ff @(negedge ser_clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            start  <= 1'b0;
        end else begin
            sync_q <= frame_sync;
            start  <= frame_sync & ~sync_q;
        end
    end
endmodule

// File: rtl/aclink_frame_builder.sv
module aclink_frame_builder
    import aclink_in_pkg::*;
#(
    parameter int ADC_W = 18
) (
    input  status_t          st,
    input  logic [ADC_W-1:0] left,
    input  logic             left_ok,
    input  logic [ADC_W-1:0] right,
    input  logic             right_ok,
    output frame_t           frame
);
    localparam int DATA_BASE = FRAME_W - TAG_W;

    slot_t                slots [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] tags;

    function automatic slot_t justify(logic [ADC_W-1:0] s, logic ok);
        slot_t r;
        r = '0;
        if (ok) r[SLOT_W-1 -: ADC_W] = s;
        return r;
    endfunction

    always_comb begin
        for (int k = 0; k < NUM_SLOTS; k++) slots[k] = '0;
        slots[0] = make_addr_slot(st);
        slots[1] = make_data_slot(st);
        slots[2] = justify(left, left_ok);
        slots[3] = justify(right, right_ok);
    end

    always_comb begin
        tags = '0;
        tags[NUM_SLOTS-1] = st.valid;
        tags[NUM_SLOTS-2] = st.valid;
        tags[NUM_SLOTS-3] = left_ok;
        tags[NUM_SLOTS-4] = right_ok;
    end

    assign frame[FRAME_W-1 -: TAG_W] = make_tag(st.ready, tags);

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        assign frame[DATA_BASE-1-k*SLOT_W -: SLOT_W] = slots[k];
    end
endmodule

// File: rtl/aclink_shift_out.sv
module aclink_shift_out #(
    parameter int W = 256
) (
    input  logic         ser_clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] frame,
    output logic         ser_out
);
    logic [W-1:0] sh;

    // MSB leaves first; zeros fill in behind so the line idles low
    always_ff @(posedge ser_clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= frame;
        else           sh <= {sh[W-2:0], 1'b0};
    end

    assign ser_out = sh[W-1];
endmodule

// File: rtl/aclink_in_serializer.sv
module aclink_in_serializer
    import aclink_in_pkg::*;
#(
    parameter int ADC_W = 18
) (
    input  logic             ser_clk,
    input  logic             rst,
    input  logic             frame_sync,
    input  logic             dev_ready,
    input  logic [6:0]       reg_idx,
    input  logic [15:0]      reg_data,
    input  logic             reg_valid,
    input  logic [9:0]       rate_req,
    input  logic [ADC_W-1:0] rec_left,
    input  logic             rec_left_valid,
    input  logic [ADC_W-1:0] rec_right,
    input  logic             rec_right_valid,
    output logic             ser_out
);
    logic    start_w;
    status_t st;
    frame_t  frame_w;

    always_comb begin
        st.ready = dev_ready;
        st.idx   = reg_idx;
        st.data  = reg_data;
        st.valid = reg_valid;
        st.req   = rate_req;
    end

    aclink_sync_detect sync_i (
        .ser_clk   (ser_clk),
        .rst       (rst),
        .frame_sync(frame_sync),
        .start     (start_w)
    );

    aclink_frame_builder #(.ADC_W(ADC_W)) build_i (
        .st      (st),
        .left    (rec_left),
        .left_ok (rec_left_valid),
        .right   (rec_right),
        .right_ok(rec_right_valid),
        .frame   (frame_w)
    );

    aclink_shift_out #(.W(FRAME_W)) shift_i (
        .ser_clk(ser_clk),
        .rst    (rst),
        .load   (start_w),
        .frame  (frame_w),
        .ser_out(ser_out)
    );
endmodule

// File: rtl/aclink_in_checker.sv
module aclink_in_checker
    import aclink_in_pkg::*;
(
    input logic ser_clk,
    input logic rst,
    input logic start,
    input logic dev_ready,
    input logic reg_valid,
    input logic ser_out
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_W);
    localparam int S2_LO = TAG_W + 2*SLOT_W - 4;
    localparam int S2_HI = TAG_W + 2*SLOT_W;

    logic [CNT_W-1:0] pos;
    logic             valid_q;

    // pos = index of the bit currently on the line, CNT_END when idle
    always_ff @(posedge ser_clk) begin
        if (rst) begin
            pos     <= CNT_END;
            valid_q <= 1'b0;
        end else if (start) begin
            pos     <= '0;
            valid_q <= reg_valid;
        end else if (pos != CNT_END) begin
            pos <= pos + 1'b1;
        end
    end

    function automatic logic stuffed(int p);
        return (p >= 1 + USED_SLOTS && p < TAG_W)
            || (p == TAG_W)
            || (p == TAG_W + SLOT_W - 2) || (p == TAG_W + SLOT_W - 1)
            || (p >= S2_LO && p < S2_HI)
            || (p >= TAG_W + USED_SLOTS*SLOT_W && p < FRAME_W);
    endfunction

    AST_READY_FIRST: assert property (@(posedge ser_clk) disable iff (rst)
        start |=> (ser_out == $past(dev_ready))); // R1
    AST_TAG_SLOT1: assert property (@(posedge ser_clk) disable iff (rst)
        (pos == CNT_W'(1)) |-> (ser_out == valid_q)); // R3
    AST_STUFF_ZERO: assert property (@(posedge ser_clk) disable iff (rst)
        stuffed(int'(pos)) |-> !ser_out); // R7
    AST_SLOT2_BLANK: assert property (@(posedge ser_clk) disable iff (rst)
        (int'(pos) >= TAG_W + SLOT_W && int'(pos) < S2_HI && !valid_q) |-> !ser_out); // R5
    AST_IDLE_ZERO: assert property (@(posedge ser_clk) disable iff (rst)
        (pos == CNT_END) |-> !ser_out); // R9
endmodule

bind aclink_in_serializer aclink_in_checker chk_i (
    .ser_clk  (ser_clk),
    .rst      (rst),
    .start    (start_w),
    .dev_ready(dev_ready),
    .reg_valid(reg_valid),
    .ser_out  (ser_out)
);

// File: tb/aclink_in_serializer_tb.sv
module aclink_in_serializer_tb_top;
    localparam int ADC_W = 18;

    logic             ser_clk = 1'b0;
    logic             rst = 1'b1;
    logic             frame_sync = 1'b0;
    logic             dev_ready = 1'b0;
    logic [6:0]       reg_idx = '0;
    logic [15:0]      reg_data = '0;
    logic             reg_valid = 1'b0;
    logic [9:0]       rate_req = '0;
    logic [ADC_W-1:0] rec_left = '0;
    logic             rec_left_valid = 1'b0;
    logic [ADC_W-1:0] rec_right = '0;
    logic             rec_right_valid = 1'b0;
    logic             ser_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // expected snapshot of the inputs at frame start
    logic             e_rdy, e_rv, e_lv, e_rrv;
    logic [6:0]       e_idx;
    logic [15:0]      e_data;
    logic [9:0]       e_req;
    logic [ADC_W-1:0] e_l, e_r;

    always #10 ser_clk = ~ser_clk;

    aclink_in_serializer #(.ADC_W(ADC_W)) dut_i (
        .ser_clk(ser_clk), .rst(rst), .frame_sync(frame_sync),
        .dev_ready(dev_ready), .reg_idx(reg_idx), .reg_data(reg_data),
        .reg_valid(reg_valid), .rate_req(rate_req),
        .rec_left(rec_left), .rec_left_valid(rec_left_valid),
        .rec_right(rec_right), .rec_right_valid(rec_right_valid),
        .ser_out(ser_out)
    );

    task automatic chk(logic got, logic exp, string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", what, got, exp);
        end
    endtask

    function automatic logic exp_bit(int p);
        int s, b;
        if (p < 16) begin
            b = 15 - p;
            if (b == 15) return e_rdy;
            if (b == 14 || b == 13) return e_rv;
            if (b == 12) return e_lv;
            if (b == 11) return e_rrv;
            return 1'b0;
        end
        s = (p - 16) / 20 + 1;
        b = 19 - (p - 16) % 20;
        case (s)
            1: begin
                if (b <= 18 && b >= 12) return e_rv ? e_idx[b-12] : 1'b0;
                if (b <= 11 && b >= 2) return e_req[b-2];
                return 1'b0;
            end
            2: return (e_rv && b >= 4) ? e_data[b-4] : 1'b0;
            3: return (e_lv && b >= 20-ADC_W) ? e_l[b-(20-ADC_W)] : 1'b0;
            4: return (e_rrv && b >= 20-ADC_W) ? e_r[b-(20-ADC_W)] : 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(int p);
        if (p == 0) return "R1";
        if (p < 16) return "R3";
        if (p < 36) return "R4";
        if (p < 56) return "R5";
        if (p < 96) return "R6";
        return "R7";
    endfunction

    task automatic scramble();
        logic [31:0] t;
        t = $urandom; dev_ready = t[0]; reg_valid = t[1];
        rec_left_valid = t[2]; rec_right_valid = t[3]; reg_idx = t[10:4];
        rate_req = t[20:11];
        t = $urandom; reg_data = t[15:0];
        t = $urandom; rec_left = t[ADC_W-1:0];
        t = $urandom; rec_right = t[ADC_W-1:0];
    endtask

    // pre_raised: strobe already raised by the previous frame
    // raise_at: bit index on which the next strobe edge is given (-1 none)
    task automatic run_frame(bit pre_raised, int raise_at, bit drop_sync, string ctx);
        int last;
        last = (raise_at >= 0) ? raise_at : 255;
        if (!pre_raised) begin
            @(posedge ser_clk); #2; frame_sync = 1'b1;
        end
        e_rdy = dev_ready; e_rv = reg_valid; e_lv = rec_left_valid;
        e_rrv = rec_right_valid; e_idx = reg_idx; e_data = reg_data;
        e_req = rate_req; e_l = rec_left; e_r = rec_right;
        for (int i = 0; i <= last; i++) begin
            @(posedge ser_clk); #2;
            if (i == 1) scramble();            // R8: later changes ignored
            if (i == 16 && drop_sync) frame_sync = 1'b0;
            if (i == raise_at) frame_sync = 1'b1;
            @(negedge ser_clk);
            chk(ser_out, exp_bit(i),
                $sformatf("%s %s bit%0d (R2 order, R8 capture)", ctx, req_of(i), i));
        end
    endtask

    task automatic check_idle(int n, string ctx);
        for (int i = 0; i < n; i++) begin
            @(negedge ser_clk);
            chk(ser_out, 1'b0, ctx);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        void'($urandom(32'd7));
        repeat (3) @(posedge ser_clk);
        check_idle(2, "R9 reset output");
        @(posedge ser_clk); #2; rst = 1'b0;
        check_idle(5, "R9 idle after reset");

        // directed: everything valid, all ones
        dev_ready = 1; reg_valid = 1; rec_left_valid = 1; rec_right_valid = 1;
        reg_idx = '1; reg_data = '1; rate_req = '1; rec_left = '1; rec_right = '1;
        run_frame(0, -1, 1, "all-ones");
        check_idle(4, "R9 after bit 255");

        // directed: nothing valid, data all ones (R4 request bits still sent)
        dev_ready = 0; reg_valid = 0; rec_left_valid = 0; rec_right_valid = 0;
        reg_idx = '1; reg_data = '1; rate_req = 10'h2A5; rec_left = '1; rec_right = '1;
        run_frame(0, -1, 1, "untagged");
        check_idle(3, "R9 after untagged");

        // random frames, then a back-to-back chain
        for (int k = 0; k < 4; k++) begin
            scramble();
            run_frame(0, -1, 1, "random");
        end
        scramble();
        run_frame(0, 255, 1, "chain-a");
        scramble();
        run_frame(1, -1, 1, "R10 back-to-back");
        check_idle(3, "R9 after chain");

        // mid-frame restart
        scramble();
        run_frame(0, 100, 1, "pre-restart");
        scramble();
        run_frame(1, -1, 1, "R10 mid-frame restart");

        // strobe held high, then dropped: no new frame
        scramble();
        run_frame(0, -1, 0, "held-strobe");
        check_idle(20, "R11 strobe held high");
        @(posedge ser_clk); #2; frame_sync = 1'b0;
        check_idle(10, "R11 strobe falling");

        for (int k = 0; k < 3; k++) begin
            scramble();
            run_frame(0, -1, 1, "random-tail");
        end
        check_idle(2, "R9 final idle");
        finish_up();
    end
endmodule